// File: doc/BRIEF.md
# Transparent Timing-Message Forwarder

This block sits at a mesh node between a timing master, connected on its north side, and two timing slaves, connected on its east and west sides. It moves 34-bit timing messages from one side to another. Every transfer, in or out, uses a request/grant handshake.

The node owns a single holding register. When the register is empty, the node picks one requesting input under a fixed priority. It grants that input and captures the message at the next clock edge. It then decodes the destination nibble and raises output requests toward every port the message must reach. The nibble value all-ones is a broadcast, as used for sync and follow-up messages. Such a message is copied to the two sides other than the one it came from. A master broadcast therefore reaches both slaves.

Each output request drops on its own grant. The register frees itself once every target has taken the message. A destination that names no neighbour is discarded and reported on a one-cycle error strobe. Timestamp correction is left to the endpoints. This node adds a fixed one-cycle residence.

Top module: `tc_forwarder`

## Requirements
- R1: After reset, all output requests, all input grants and the error strobe are low.
- R2: The destination is message bits [7:4]. The value 4'hF is a broadcast. It raises output requests on the two ports other than its source. A broadcast from north requests east and west.
- R3: A broadcast completes only when both targets have granted. Each output request drops after the edge on which it is granted. No input is granted while any target is still outstanding.
- R4: A non-broadcast destination that equals a port's address parameter requests that port alone. The defaults are east 9, west 7 and north 5.
- R5: A message accepted on edge k drives its output request(s) in the cycle after edge k. It carries the accepted message unchanged. If granted in that cycle, it is gone after the next edge.
- R6: Input priority is east over west over north. When east and west request together, east is granted and west is not.
- R7: A losing input stays ungranted while the holding register is occupied. It is granted in the cycle after the last outstanding output grant.
- R8: A message whose destination matches no port other than its source is dropped. No output request is raised. The error strobe is high for the single cycle after acceptance.
- R9: While an output request is high and ungranted, that request and the output message stay stable.
- R10: At most one input grant is high at a time. Grants are given only while the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e_req_i | input | 1 | East slave offers a message |
| e_msg_i | input | 34 | East incoming message |
| e_gnt_o | output | 1 | Node accepts the east message |
| w_req_i | input | 1 | West slave offers a message |
| w_msg_i | input | 34 | West incoming message |
| w_gnt_o | output | 1 | Node accepts the west message |
| n_req_i | input | 1 | Master offers a message |
| n_msg_i | input | 34 | North incoming message |
| n_gnt_o | output | 1 | Node accepts the north message |
| e_req_o | output | 1 | Node offers a message eastward |
| e_msg_o | output | 34 | Outgoing message to east |
| e_gnt_i | input | 1 | East slave takes the message |
| w_req_o | output | 1 | Node offers a message westward |
| w_msg_o | output | 34 | Outgoing message to west |
| w_gnt_i | input | 1 | West slave takes the message |
| n_req_o | output | 1 | Node offers a message northward |
| n_msg_o | output | 34 | Outgoing message to north |
| n_gnt_i | input | 1 | Master takes the message |
| err_o | output | 1 | Unroutable message was dropped |

## Verification
Input arbitration and draining of the holding register can meet in the same cycle. There is also the simpler clash of east and west raising requests together. The bench starts both slave requests on the same edge, with east expected to win. It keeps west requesting while the east message waits for its north grant. West must stay ungranted until the cycle right after that grant. A broadcast with staggered downstream grants likewise shows that a new north request is refused until the second target has taken the message.

// File: rtl/tcfwd_pkg.sv
package tcfwd_pkg;
    localparam int MSG_W   = 34;
    localparam int DST_LSB = 4;
    localparam int DST_W   = 4;
    localparam int NPORT   = 3;

    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [DST_W-1:0] addr_t;
    typedef logic [NPORT-1:0] pmask_t;

    localparam addr_t BCAST = '1;

    // Index order doubles as arbitration priority (lowest index wins).
    typedef enum logic [1:0] {
        PORT_E = 2'd0,
        PORT_W = 2'd1,
        PORT_N = 2'd2
    } port_e;

    typedef struct packed {
        logic  vld;
        port_e src;
        msg_t  msg;
    } cand_t;

    function automatic addr_t dst_of(msg_t m);
        return m[DST_LSB +: DST_W];
    endfunction

    function automatic pmask_t route_mask(port_e src, addr_t dst,
                                          addr_t a_e, addr_t a_w, addr_t a_n);
        pmask_t m;
        m = '0;
        if (dst == BCAST) begin
            m = '1;
        end else begin
            if (dst == a_e) m[PORT_E] = 1'b1;
            if (dst == a_w) m[PORT_W] = 1'b1;
            if (dst == a_n) m[PORT_N] = 1'b1;
        end
        m[src] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/tc_arb.sv
module tc_arb
    import tcfwd_pkg::*;
#(
    parameter int N = NPORT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/tc_route.sv
module tc_route
    import tcfwd_pkg::*;
#(
    parameter addr_t ADDR_E = 4'd9,
    parameter addr_t ADDR_W = 4'd7,
    parameter addr_t ADDR_N = 4'd5
) (
    input  cand_t  cand,
    output pmask_t mask,
    output logic   bad
);
    always_comb begin
        mask = '0;
        if (cand.vld)
            mask = route_mask(cand.src, dst_of(cand.msg), ADDR_E, ADDR_W, ADDR_N);
        bad = cand.vld && (mask == '0);
    end
endmodule

// File: rtl/tc_hold.sv
module tc_hold
    import tcfwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc,
    input  pmask_t acc_mask,
    input  logic   acc_bad,
    input  msg_t   acc_msg,
    input  pmask_t out_gnt,
    output pmask_t out_req,
    output msg_t   out_msg,
    output logic   empty,
    output logic   err
);
    pmask_t pend_q;
    msg_t   data_q;
    logic   err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= acc && acc_bad;
            if (acc && !acc_bad) begin
                pend_q <= acc_mask;
                data_q <= acc_msg;
            end else begin
                pend_q <= pend_q & ~out_gnt;
            end
        end
    end

    assign out_req = pend_q;
    assign out_msg = data_q;
    assign empty   = (pend_q == '0);
    assign err     = err_q;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_chk
            p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
                (out_req[g] && !out_gnt[g]) |=> (out_req[g] && $stable(out_msg)));
            p_drop_on_grant_r3: assert property (@(posedge clk) disable iff (rst)
                (out_req[g] && out_gnt[g]) |=> !out_req[g]);
        end
    endgenerate

    p_no_new_target_r3: assert property (@(posedge clk) disable iff (rst)
        (!empty) |=> ((out_req & ~$past(out_req)) == '0));
    p_err_silent_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> (out_req == '0));
endmodule

// File: rtl/tc_forwarder.sv
module tc_forwarder
    import tcfwd_pkg::*;
#(
    parameter addr_t ADDR_E = 4'd9,
    parameter addr_t ADDR_W = 4'd7,
    parameter addr_t ADDR_N = 4'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              e_req_i,
    input  logic [MSG_W-1:0]  e_msg_i,
    output logic              e_gnt_o,
    input  logic              w_req_i,
    input  logic [MSG_W-1:0]  w_msg_i,
    output logic              w_gnt_o,
    input  logic              n_req_i,
    input  logic [MSG_W-1:0]  n_msg_i,
    output logic              n_gnt_o,
    output logic              e_req_o,
    output logic [MSG_W-1:0]  e_msg_o,
    input  logic              e_gnt_i,
    output logic              w_req_o,
    output logic [MSG_W-1:0]  w_msg_o,
    input  logic              w_gnt_i,
    output logic              n_req_o,
    output logic [MSG_W-1:0]  n_msg_o,
    input  logic              n_gnt_i,
    output logic              err_o
);
    pmask_t in_req, in_gnt, out_req, out_gnt, rt_mask;
    msg_t   in_msg [NPORT];
    msg_t   hold_msg;
    cand_t  cand;
    logic   empty, acc, rt_bad;

    assign in_req = {n_req_i, w_req_i, e_req_i};
    assign out_gnt = {n_gnt_i, w_gnt_i, e_gnt_i};
    assign in_msg[PORT_E] = e_msg_i;
    assign in_msg[PORT_W] = w_msg_i;
    assign in_msg[PORT_N] = n_msg_i;

    tc_arb #(.N(NPORT)) u_arb (
        .clk (clk),
        .rst (rst),
        .en  (empty),
        .req (in_req),
        .gnt (in_gnt)
    );

    always_comb begin
        cand = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (in_gnt[i]) begin
                cand.vld = 1'b1;
                cand.src = port_e'(i);
                cand.msg = in_msg[i];
            end
        end
    end

    assign acc = cand.vld;

    tc_route #(.ADDR_E(ADDR_E), .ADDR_W(ADDR_W), .ADDR_N(ADDR_N)) u_route (
        .cand (cand),
        .mask (rt_mask),
        .bad  (rt_bad)
    );

    tc_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_mask (rt_mask),
        .acc_bad  (rt_bad),
        .acc_msg  (cand.msg),
        .out_gnt  (out_gnt),
        .out_req  (out_req),
        .out_msg  (hold_msg),
        .empty    (empty),
        .err      (err_o)
    );

    assign e_gnt_o = in_gnt[PORT_E];
    assign w_gnt_o = in_gnt[PORT_W];
    assign n_gnt_o = in_gnt[PORT_N];
    assign e_req_o = out_req[PORT_E];
    assign w_req_o = out_req[PORT_W];
    assign n_req_o = out_req[PORT_N];
    assign e_msg_o = hold_msg;
    assign w_msg_o = hold_msg;
    assign n_msg_o = hold_msg;

    p_east_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (e_req_i && w_req_i) |-> !w_gnt_o);
    p_busy_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
        (out_req != '0) |-> ({n_gnt_o, w_gnt_o, e_gnt_o} == 3'b000));
    p_residence_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && rt_mask != '0) |=> (out_req == $past(rt_mask)));
    p_err_after_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && rt_bad) |=> err_o);
endmodule

// File: tb/tc_forwarder_tb.sv
module tc_forwarder_tb;
    import tcfwd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0] rq;
    logic [2:0] og;
    msg_t       mi [3];
    wire  [2:0] gi;
    wire  [2:0] orq;
    msg_t       mo [3];
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tc_forwarder u_dut (
        .clk(clk), .rst(rst),
        .e_req_i(rq[0]), .e_msg_i(mi[0]), .e_gnt_o(gi[0]),
        .w_req_i(rq[1]), .w_msg_i(mi[1]), .w_gnt_o(gi[1]),
        .n_req_i(rq[2]), .n_msg_i(mi[2]), .n_gnt_o(gi[2]),
        .e_req_o(orq[0]), .e_msg_o(mo[0]), .e_gnt_i(og[0]),
        .w_req_o(orq[1]), .w_msg_o(mo[1]), .w_gnt_i(og[1]),
        .n_req_o(orq[2]), .n_msg_o(mo[2]), .n_gnt_i(og[2]),
        .err_o(err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {src[1:0], dst[3:0], expected mask[2:0] (bit0 E, bit1 W, bit2 N), expected err}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        {2'd2, 4'hF, 3'b011, 1'b0},
        {2'd0, 4'h5, 3'b100, 1'b0},
        {2'd1, 4'h5, 3'b100, 1'b0},
        {2'd2, 4'h9, 3'b001, 1'b0},
        {2'd2, 4'h7, 3'b010, 1'b0},
        {2'd0, 4'hF, 3'b110, 1'b0},
        {2'd1, 4'hF, 3'b101, 1'b0},
        {2'd0, 4'h7, 3'b010, 1'b0},
        {2'd2, 4'h3, 3'b000, 1'b1},
        {2'd0, 4'h9, 3'b000, 1'b1},
        {2'd2, 4'h5, 3'b000, 1'b1},
        {2'd1, 4'h9, 3'b001, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        msg_t ma, mb;
        rq = '0; og = '0;
        for (int k = 0; k < 3; k++) mi[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 out requests", 64'(orq), 64'd0);
        chk("R1 grants", 64'(gi), 64'd0);
        chk("R1 err", 64'(err), 64'd0);

        for (int i = 0; i < NV; i++) begin
            int    s;
            logic [3:0] d;
            logic [2:0] em;
            logic  ee;
            string tg;
            msg_t  m;
            s  = int'(VEC[i][9:8]);
            d  = VEC[i][7:4];
            em = VEC[i][3:1];
            ee = VEC[i][0];
            tg = ee ? "R8" : ((d == 4'hF) ? "R2" : "R4");
            m  = {26'(i * 977 + 3), d, 4'(i)};
            @(negedge clk);
            rq[s] = 1'b1; mi[s] = m;
            #1 chk("R10 single grant", 64'(gi), 64'(3'b001 << s));
            @(negedge clk);
            rq = '0;
            #1 chk({tg, " route"}, 64'(orq), 64'(em));
            chk("R8 err strobe", 64'(err), 64'(ee));
            for (int k = 0; k < 3; k++)
                if (em[k]) chk("R5 message carried", 64'(mo[k]), 64'(m));
            og = em;
            @(negedge clk);
            og = '0;
            #1 chk("R5 cleared after grant", 64'(orq), 64'd0);
            chk("R8 err one cycle", 64'(err), 64'd0);
        end

        // Simultaneous east and west: east first, west waits (R6, R7)
        ma = {26'h1234567, 4'h5, 4'h1};
        mb = {26'h0ABCDEF, 4'h5, 4'h2};
        @(negedge clk);
        rq[0] = 1'b1; mi[0] = ma; rq[1] = 1'b1; mi[1] = mb;
        #1 chk("R6 east granted first", 64'(gi), 64'b001);
        @(negedge clk);
        rq[0] = 1'b0;
        #1 chk("R7 west waits while busy", 64'(gi[1]), 64'd0);
        chk("R6 east message north", 64'(mo[2]), 64'(ma));
        @(negedge clk);
        #1 chk("R7 west still waits ungranted north", 64'(gi[1]), 64'd0);
        chk("R9 north held", 64'(mo[2]), 64'(ma));
        og[2] = 1'b1;
        @(negedge clk);
        og[2] = 1'b0;
        #1 chk("R7 west served next cycle", 64'(gi), 64'b010);
        @(negedge clk);
        rq[1] = 1'b0;
        #1 chk("R7 west message north", 64'(mo[2]), 64'(mb));
        chk("R7 north request", 64'(orq), 64'b100);
        og[2] = 1'b1;
        @(negedge clk);
        og[2] = 1'b0;

        // Broadcast with staggered grants (R3, R9)
        ma = {26'h2AAAAAA, 4'hF, 4'h3};
        mb = {26'h1555555, 4'h9, 4'h4};
        @(negedge clk);
        rq[2] = 1'b1; mi[2] = ma;
        @(negedge clk);
        mi[2] = mb;
        #1 chk("R3 both targets", 64'(orq), 64'b011);
        og[0] = 1'b1;
        @(negedge clk);
        og[0] = 1'b0;
        #1 chk("R3 east dropped west pending", 64'(orq), 64'b010);
        chk("R3 no accept while pending", 64'(gi), 64'd0);
        @(negedge clk);
        #1 chk("R9 west held stable", 64'(mo[1]), 64'(ma));
        chk("R9 west request held", 64'(orq), 64'b010);
        og[1] = 1'b1;
        @(negedge clk);
        og[1] = 1'b0;
        #1 chk("R3 complete frees node", 64'(orq), 64'd0);
        chk("R10 next north granted", 64'(gi), 64'b100);
        @(negedge clk);
        rq[2] = 1'b0;
        #1 chk("R4 addressed east only", 64'(orq), 64'b001);
        og[0] = 1'b1;
        @(negedge clk);
        og = '0;
        #1 chk("R4 done", 64'(orq), 64'd0);

        // Reset in mid-transfer (R1)
        @(negedge clk);
        rq[2] = 1'b1; mi[2] = ma;
        @(negedge clk);
        rq = '0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 reset clears pending", 64'(orq), 64'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule